// File: doc/BRIEF.md
# Signed-Digit Decimal Partial Product Generator

This block is the front end of a parallel decimal multiplier. It takes a multiplicand X and a multiplier Y, each made of `NDIG` packed BCD digits (8421 code). It returns the `NDIG+1` partial products whose weighted sum is X·Y. Each multiplier digit is recoded into a signed digit in the range -5..+5, with no carry chain between digits. The signed digit then picks one of the shared multiples 0, X, 2X, 3X, 4X or 5X. A negative digit inverts the chosen multiple.

Partial products leave the block in BCD-4221 code. Partial product j carries weight 10^j, so a downstream reduction tree shifts each one by four bit positions from its neighbour. A negative partial product is the nine's complement of its multiple, sign-extended by one digit. The +1 that completes the ten's complement is not added here. It is reported on a separate tail bit, which the reduction tree adds at digit 0 of that partial product. An optional output register sets the latency to zero or one clock.

Top module: `sdpp_gen`

## Requirements
- R1: With t_i = 1 when multiplier digit y_i is 5 or more (t_-1 = 0), the signed digit is s_i = y_i + t_(i-1) - 10·t_i for i < NDIG, and s_NDIG = t_(NDIG-1). Partial product j, read as the value below, equals s_j·X.
- R2: tail_o[j] is 1 exactly when s_j is negative.
- R3: When s_j is zero, all bits of partial product j are 0 and tail_o[j] is 0. This includes digits that reach zero through recoding, such as 9 with an incoming transfer.
- R4: A negative partial product has its top digit coded 1111. Each of its lower NDIG+1 digits, when bit-inverted, is the 4221 code of the matching digit of |s_j|·X.
- R5: Every 4-bit digit of every partial product uses one of the codes for 0..9: 0000, 0001, 0010, 0011, 1000, 0111, 1100, 1101, 1110, 1111. A digit's value is 4·b3 + 2·b2 + 2·b1 + b0.
- R6: Partial product j occupies pp_o[j·4(NDIG+2) +: 4(NDIG+2)], least significant digit lowest. Its signed value is D + tail_o[j] - tail_o[j]·10^(NDIG+2), where D is the digits' decimal value. The sum over j of 10^j times that value equals X·Y.
- R7: The top partial product (j = NDIG) is never negative: tail_o[NDIG] is 0 and its top digit is 0000.
- R8: With REG_OUT = 1, outputs reflect the inputs present at the previous rising clock edge. While rst_ni is low, all outputs are zero. With REG_OUT = 0, the outputs are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| x_i | input | 4·NDIG | Multiplicand, packed BCD-8421, digit 0 in the low nibble |
| y_i | input | 4·NDIG | Multiplier, packed BCD-8421, digit 0 in the low nibble |
| pp_o | output | 4·(NDIG+1)·(NDIG+2) | NDIG+1 partial products in BCD-4221, each NDIG+2 digits |
| tail_o | output | NDIG+1 | Ten's-complement completion bit for each partial product |

## Verification
The assertions assume that every nibble of x_i and y_i is a valid BCD digit 0..9. The code-validity and extension-digit properties only hold under that condition. The stimulus stays inside it by building both operands from decimal integers in a small two-digit configuration. It sweeps every pair from 00 to 99, so all nines, all fives, zero and every recoding transfer pattern are reached. The outputs are checked only after reset has been released.

// File: rtl/sdpp_pkg.sv
package sdpp_pkg;

   // BCD-8421 digit to self-complementing BCD-4221 digit (weights 4,2,2,1)
   function automatic logic [3:0] bcd_to_4221(input logic [3:0] v);
      logic [3:0] r;
      case (v)
         4'd0:    r = 4'b0000;
         4'd1:    r = 4'b0001;
         4'd2:    r = 4'b0010;
         4'd3:    r = 4'b0011;
         4'd4:    r = 4'b1000;
         4'd5:    r = 4'b0111;
         4'd6:    r = 4'b1100;
         4'd7:    r = 4'b1101;
         4'd8:    r = 4'b1110;
         4'd9:    r = 4'b1111;
         default: r = 4'b0000;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/sdpp_recode.sv
module sdpp_recode #(
   parameter int NDIG = 4
) (
   input  logic [4*NDIG-1:0]   y_i,
   output logic [NDIG:0][2:0]  mag_o,
   output logic [NDIG:0]       neg_o
);

   logic [NDIG-1:0] xfer;

   for (genvar i = 0; i < NDIG; i++) begin : g_dig
      logic [3:0] yd;
      logic [3:0] s;
      logic       cin;

      assign yd      = y_i[4*i +: 4];
      assign xfer[i] = (yd >= 4'd5);

      if (i == 0) begin : g_lsd
         assign cin = 1'b0;
      end else begin : g_up
         assign cin = xfer[i-1];
      end

      // digit plus incoming transfer, 0..10
      assign s        = yd + {3'b000, cin};
      assign mag_o[i] = 3'(xfer[i] ? (4'd10 - s) : s);
      assign neg_o[i] = xfer[i] & (s != 4'd10);
   end

   // extra digit produced by the transfer out of the top multiplier digit
   assign mag_o[NDIG] = {2'b00, xfer[NDIG-1]};
   assign neg_o[NDIG] = 1'b0;

endmodule

// File: rtl/sdpp_dbl.sv
module sdpp_dbl #(
   parameter int ND = 5
) (
   input  logic [ND-1:0][3:0] a_i,
   output logic [ND-1:0][3:0] q_o
);

   // carry-free BCD doubling: each digit only sees its lower neighbour
   for (genvar i = 0; i < ND; i++) begin : g_dig
      logic [4:0] tw;
      logic [3:0] lo;
      logic       cin;

      assign tw = {a_i[i], 1'b0};
      assign lo = (tw >= 5'd10) ? 4'(tw - 5'd10) : tw[3:0];

      if (i == 0) begin : g_lsd
         assign cin = 1'b0;
      end else begin : g_up
         assign cin = (a_i[i-1] >= 4'd5);
      end

      assign q_o[i] = lo + {3'b000, cin};
   end

endmodule

// File: rtl/sdpp_multiples.sv
module sdpp_multiples
   import sdpp_pkg::*;
#(
   parameter int NDIG = 4,
   localparam int ND = NDIG + 1,
   localparam int MW = 4 * ND
) (
   input  logic [4*NDIG-1:0]    x_i,
   output logic [5:1][MW-1:0]   mult_o
);

   logic [ND-1:0][3:0] b1, b2, b3, b4, b5;
   logic [5:1][ND-1:0][3:0] bm;
   logic [ND-1:0] c3;

   assign b1 = {4'h0, x_i};

   sdpp_dbl #(.ND(ND)) u_dbl2 (.a_i(b1), .q_o(b2));
   sdpp_dbl #(.ND(ND)) u_dbl4 (.a_i(b2), .q_o(b4));

   // 3X = 2X + X, decimal ripple add
   assign c3[0] = 1'b0;
   for (genvar i = 0; i < ND; i++) begin : g_add3
      logic [4:0] s;
      logic       cy;
      assign s     = {1'b0, b1[i]} + {1'b0, b2[i]} + {4'b0000, c3[i]};
      assign cy    = (s >= 5'd10);
      assign b3[i] = cy ? 4'(s - 5'd10) : s[3:0];
      if (i < ND - 1) begin : g_cy
         assign c3[i+1] = cy;
      end
   end

   // 5X = 10X / 2: digit i takes 5 from the parity of x_i plus half of x_(i-1)
   for (genvar i = 0; i < ND; i++) begin : g_five
      logic [2:0] hi;
      if (i == 0) begin : g_lsd
         assign hi = 3'd0;
      end else begin : g_up
         assign hi = b1[i-1][3:1];
      end
      assign b5[i] = (b1[i][0] ? 4'd5 : 4'd0) + {1'b0, hi};
   end

   assign bm[1] = b1;
   assign bm[2] = b2;
   assign bm[3] = b3;
   assign bm[4] = b4;
   assign bm[5] = b5;

   for (genvar m = 1; m <= 5; m++) begin : g_mul
      for (genvar k = 0; k < ND; k++) begin : g_cvt
         assign mult_o[m][4*k +: 4] = bcd_to_4221(bm[m][k]);
      end
   end

endmodule

// File: rtl/sdpp_select.sv
module sdpp_select #(
   parameter int NDIG = 4,
   localparam int MW  = 4 * (NDIG + 1),
   localparam int PPW = MW + 4
) (
   input  logic [2:0]          mag_i,
   input  logic                neg_i,
   input  logic [5:1][MW-1:0]  mult_i,
   output logic [PPW-1:0]      pp_o,
   output logic                tail_o
);

   logic [MW-1:0] sel;

   always_comb begin
      case (mag_i)
         3'd1:    sel = mult_i[1];
         3'd2:    sel = mult_i[2];
         3'd3:    sel = mult_i[3];
         3'd4:    sel = mult_i[4];
         3'd5:    sel = mult_i[5];
         default: sel = '0;
      endcase
   end

   // nine's complement by inversion, +1 deferred to the tail bit
   assign tail_o = neg_i & (mag_i != 3'd0);
   assign pp_o   = tail_o ? {4'hF, ~sel} : {4'h0, sel};

endmodule

// File: rtl/sdpp_gen.sv
module sdpp_gen #(
   parameter int NDIG    = 4,
   parameter int REG_OUT = 1,
   localparam int NPP = NDIG + 1,
   localparam int MW  = 4 * (NDIG + 1),
   localparam int PPW = MW + 4
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [4*NDIG-1:0]    x_i,
   input  logic [4*NDIG-1:0]    y_i,
   output logic [NPP*PPW-1:0]   pp_o,
   output logic [NPP-1:0]       tail_o
);

   if (NDIG < 1 || NDIG > 16) begin : g_bad_ndig
      $error("sdpp_gen: NDIG must lie in 1..16");
   end
   if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg
      $error("sdpp_gen: REG_OUT must be 0 or 1");
   end

   logic [NDIG:0][2:0]    mag;
   logic [NDIG:0]         neg;
   logic [5:1][MW-1:0]    mult;
   logic [NPP*PPW-1:0]    pp_c;
   logic [NPP-1:0]        tail_c;

   sdpp_recode #(.NDIG(NDIG)) u_recode (
      .y_i   (y_i),
      .mag_o (mag),
      .neg_o (neg)
   );

   sdpp_multiples #(.NDIG(NDIG)) u_mult (
      .x_i    (x_i),
      .mult_o (mult)
   );

   for (genvar j = 0; j < NPP; j++) begin : g_pp
      sdpp_select #(.NDIG(NDIG)) u_sel (
         .mag_i  (mag[j]),
         .neg_i  (neg[j]),
         .mult_i (mult),
         .pp_o   (pp_c[j*PPW +: PPW]),
         .tail_o (tail_c[j])
      );
   end

   if (REG_OUT == 1) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            pp_o   <= '0;
            tail_o <= '0;
         end else begin
            pp_o   <= pp_c;
            tail_o <= tail_c;
         end
      end
   end else begin : g_comb
      assign pp_o   = pp_c;
      assign tail_o = tail_c;
   end

endmodule

// File: rtl/sdpp_gen_chk.sv
module sdpp_gen_chk #(
   parameter int NDIG    = 4,
   parameter int REG_OUT = 1,
   localparam int NPP = NDIG + 1,
   localparam int MW  = 4 * (NDIG + 1),
   localparam int PPW = MW + 4
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic [4*NDIG-1:0]    x_i,
   input logic [4*NDIG-1:0]    y_i,
   input logic [NPP*PPW-1:0]   pp_o,
   input logic [NPP-1:0]       tail_o
);

   function automatic logic code_ok(input logic [3:0] c);
      return !(c inside {4'd4, 4'd5, 4'd6, 4'd9, 4'd10, 4'd11});
   endfunction

   // R7: top partial product stays positive
   p_top_positive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tail_o[NDIG] && (pp_o[NDIG*PPW + MW +: 4] == 4'h0));

   for (genvar j = 0; j < NPP; j++) begin : g_pp
      // R4: extension digit follows the sign of the partial product
      p_ext_digit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         pp_o[j*PPW + MW +: 4] == (tail_o[j] ? 4'hF : 4'h0));
      for (genvar k = 0; k < NDIG + 2; k++) begin : g_dig
         // R5: only legal 4221 codes appear
         p_code_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            code_ok(pp_o[j*PPW + 4*k +: 4]));
      end
   end

   // R8: reset clears the outputs
   p_reset_clear_r8: assert property (@(posedge clk_i)
      !rst_ni |=> (pp_o == '0 && tail_o == '0));

   if (REG_OUT == 1) begin : g_reg
      // R8: one register stage; steady inputs give steady outputs a cycle later
      p_hold_reg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($past(rst_ni) && $stable(x_i) && $stable(y_i)) |=> ($stable(pp_o) && $stable(tail_o)));
   end else begin : g_comb
      p_hold_comb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($stable(x_i) && $stable(y_i)) |-> ($stable(pp_o) && $stable(tail_o)));
   end

endmodule

bind sdpp_gen sdpp_gen_chk #(.NDIG(NDIG), .REG_OUT(REG_OUT)) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .x_i    (x_i),
   .y_i    (y_i),
   .pp_o   (pp_o),
   .tail_o (tail_o)
);

// File: tb/sdpp_gen_tb_top.sv
module sdpp_gen_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int ND  = 2;
   localparam int NPP = ND + 1;
   localparam int ND2 = ND + 2;
   localparam int PPW = 4 * ND2;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [4*ND-1:0]      x_s = '0;
   logic [4*ND-1:0]      y_s = '0;
   logic [NPP*PPW-1:0]   pp_s;
   logic [NPP-1:0]       tail_s;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdpp_gen #(.NDIG(ND), .REG_OUT(1)) dut_i (
      .clk_i  (clk),
      .rst_ni (rst_n),
      .x_i    (x_s),
      .y_i    (y_s),
      .pp_o   (pp_s),
      .tail_o (tail_s)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int dec(input logic [3:0] c);
      return 4*int'(c[3]) + 2*int'(c[2]) + 2*int'(c[1]) + int'(c[0]);
   endfunction

   function automatic bit legal(input logic [3:0] c);
      return !(c inside {4'd4, 4'd5, 4'd6, 4'd9, 4'd10, 4'd11});
   endfunction

   function automatic logic [7:0] to_bcd(input int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   function automatic longint pow10(input int n);
      longint p = 1;
      for (int i = 0; i < n; i++) p = p * 10;
      return p;
   endfunction

   function automatic longint ppval(input int j);
      longint v = 0;
      for (int k = 0; k < ND2; k++) v += longint'(dec(pp_s[j*PPW + 4*k +: 4])) * pow10(k);
      if (tail_s[j]) v = v + 1 - pow10(ND2);
      return v;
   endfunction

   task automatic check_vec(input int xa, input int yb);
      int y0, y1, t0, t1;
      int sd [NPP];
      longint sum = 0;
      y0 = yb % 10;  y1 = yb / 10;
      t0 = (y0 >= 5) ? 1 : 0;
      t1 = (y1 >= 5) ? 1 : 0;
      sd[0] = y0 - 10*t0;
      sd[1] = y1 + t0 - 10*t1;
      sd[2] = t1;
      for (int j = 0; j < NPP; j++) begin
         longint v = ppval(j);
         bit ok;
         chk(v == longint'(sd[j]*xa), $sformatf("R1 pp%0d x=%0d y=%0d", j, xa, yb), v, sd[j]*xa);
         chk(tail_s[j] == (sd[j] < 0), $sformatf("R2 tail%0d x=%0d y=%0d", j, xa, yb),
             tail_s[j], (sd[j] < 0));
         if (sd[j] == 0)
            chk(pp_s[j*PPW +: PPW] == '0 && !tail_s[j], $sformatf("R3 zero pp%0d y=%0d", j, yb),
                pp_s[j*PPW +: PPW], 0);
         if (sd[j] < 0) begin
            int mp = -sd[j] * xa;
            ok = (pp_s[j*PPW + 4*(ND2-1) +: 4] == 4'hF);
            for (int k = 0; k < ND2 - 1; k++)
               if (dec(~pp_s[j*PPW + 4*k +: 4]) != (mp / int'(pow10(k))) % 10) ok = 0;
            chk(ok, $sformatf("R4 inverted pp%0d x=%0d y=%0d", j, xa, yb), ok, 1);
         end
         ok = 1;
         for (int k = 0; k < ND2; k++) if (!legal(pp_s[j*PPW + 4*k +: 4])) ok = 0;
         chk(ok, $sformatf("R5 codes pp%0d x=%0d y=%0d", j, xa, yb), ok, 1);
         sum += v * pow10(j);
      end
      chk(sum == longint'(xa*yb), $sformatf("R6 sum x=%0d y=%0d", xa, yb), sum, xa*yb);
      chk(!tail_s[ND] && ppval(ND) >= 0, $sformatf("R7 top y=%0d", yb), ppval(ND), sd[ND]*xa);
   endtask

   initial begin
      logic [NPP*PPW-1:0] held;
      // R8 reset state with non-zero inputs applied
      x_s = to_bcd(97);
      y_s = to_bcd(58);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(pp_s == '0 && tail_s == '0, "R8 reset clears", pp_s, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_vec(97, 58);
      held = pp_s;
      // R8 latency: a new input does not appear before the next edge
      x_s = to_bcd(99);
      y_s = to_bcd(99);
      #1;
      chk(pp_s == held, "R8 output held until clock edge", pp_s, held);
      @(negedge clk);
      check_vec(99, 99);
      // exhaustive sweep of both two-digit operands
      for (int a = 0; a < 100; a++) begin
         for (int b = 0; b < 100; b++) begin
            x_s = to_bcd(a);
            y_s = to_bcd(b);
            @(negedge clk);
            check_vec(a, b);
         end
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule